// File: doc/BRIEF.md
# Oversampled serial receiver with error-tagged queue and idle timer

This block is the receive half of an asynchronous serial port. The serial line is first synchronised and then watched for a falling edge. The line is sampled at the centre of each bit, using a tick enable that runs at sixteen times the bit rate. Each completed character is written into a 16-deep queue. Every queue entry keeps its own parity and framing verdicts. The host sees the head word on a first-word-fall-through read port, together with level flags and error flags.

An 8-bit idle timer is armed from a programmable reload value. It counts whole bit times while the line is quiet. When it runs out, it reports one of two conditions: the queue is empty, or the queue still holds words. A loopback select feeds the local transmitter output into the receiver in place of the pin. A single-cycle clear strobe empties the queue. The bit-rate divider and the interrupt masking are outside this block: `tick_i` is an input.

Top module: `uart_rx_tout`

## Requirements
- R1: Read word layout. Bits 8:0 hold the payload bits in arrival order, so bit 0 is the first bit after the start bit, and unused high bits are 0. Bit 9 is 1 if that entry had a parity or framing error. The payload length is set by `fmt_i`: 0 gives 7 data bits; 1 gives 8 data bits; 2 gives 7 data bits plus parity, with parity in bit 7; 3 gives 8 data bits plus parity, with parity in bit 8; 4 gives 9 data bits, with bit 8 as the wake-up bit. Codes 5 to 7 behave as code 1.
- R2: A falling edge on the selected line starts a start-bit check, but only while `rx_en_i` is 1. The line is sampled on the 8th tick after the edge. If it reads 1 there, the event is discarded and nothing is queued. While `rx_en_i` is 0, nothing is received.
- R3: In formats 2 and 3, an entry has a parity error when the XOR of its payload bits, parity bit included, differs from `parity_odd_i`. `parity_odd_i` = 0 selects even parity. `parity_err_o` is 1 while any queued entry has a parity error.
- R4: `stop_two_i` = 0 checks one stop bit and `stop_two_i` = 1 checks two. A checked stop bit that samples 0 marks the entry as a framing error. `frame_err_o` is 1 while any queued entry has a framing error.
- R5: `half_full_o` is 1 when the queue holds more than 8 words. `full_o` is 1 when it holds 16.
- R6: A character that completes while the queue is full, with no read in the same cycle, is dropped and the stored entries are kept. `overrun_o` is then set and stays set until a clear.
- R7: A character that completes in the same cycle as a read of a full queue is stored. `full_o` stays 1 and `overrun_o` stays 0.
- R8: A `fifo_clr_i` pulse empties the queue by the next cycle. It also drops `overrun_o`, `parity_err_o` and `frame_err_o`. A character completing in the same cycle is discarded.
- R9: The idle timer behaves as follows.
  - It reloads from `tout_reload_i` on every completed character, on every read of a non-empty queue, and on every clear. A reload also drops both timeout flags.
  - It counts down once per 16 ticks while the receiver is idle.
  - When it reaches zero, it sets `tout_idle_o` if the queue is empty, otherwise `tout_busy_o`.
  - A reload value of 0 never expires.
- R10: With `loopback_i` = 1, the receiver takes `tx_loop_i` as its line and ignores `rx_i`.
- R11: `rd_data_o` shows the oldest word whenever `empty_o` is 0. `rd_en_i` pops one word per cycle. A read of an empty queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | External serial line |
| tx_loop_i | input | 1 | Local transmitter output, used in loopback |
| loopback_i | input | 1 | 1 selects tx_loop_i as the line |
| rx_en_i | input | 1 | Receive enable |
| fmt_i | input | 3 | Character format code (R1) |
| parity_odd_i | input | 1 | 1 odd parity, 0 even parity |
| stop_two_i | input | 1 | 1 checks two stop bits |
| tick_i | input | 1 | Enable at 16 times the bit rate |
| tout_reload_i | input | 8 | Idle timer reload value |
| fifo_clr_i | input | 1 | Strobe that empties the queue |
| rd_en_i | input | 1 | Pop the head word |
| rd_data_o | output | 10 | Head word: error tag and payload |
| empty_o | output | 1 | Queue empty |
| full_o | output | 1 | Queue holds 16 words |
| half_full_o | output | 1 | Queue holds more than 8 words |
| overrun_o | output | 1 | A character was dropped on a full queue |
| parity_err_o | output | 1 | Some queued entry has a parity error |
| frame_err_o | output | 1 | Some queued entry has a framing error |
| tout_idle_o | output | 1 | Timer expired with the queue empty |
| tout_busy_o | output | 1 | Timer expired with words waiting |

## Verification
The case that needs care is a character completing in the very cycle the host pops a full queue. That single cycle decides whether the word is stored or counted as an overrun.

The bench first sends a calibration character into an empty queue, starting from a fixed tick phase. It measures how many cycles pass before `empty_o` falls. It then fills the queue and sends another character from the same phase, pulsing `rd_en_i` exactly on the completion cycle.

The result is judged at the ports: `full_o` must stay high and `overrun_o` low. The scoreboard must then drain words 1 to 15 followed by the new character.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    FMT_D7  = 3'd0,
    FMT_D8  = 3'd1,
    FMT_D7P = 3'd2,
    FMT_D8P = 3'd3,
    FMT_D9  = 3'd4
  } rx_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic       par_err;
    logic       frm_err;
    logic [8:0] pay;
  } rx_entry_t;

  // payload bits after the start bit, parity included
  function automatic logic [3:0] fmt_bits(input logic [2:0] fmt);
    case (fmt)
      FMT_D7:           return 4'd7;
      FMT_D7P, FMT_D8:  return 4'd8;
      FMT_D8P, FMT_D9:  return 4'd9;
      default:          return 4'd8;
    endcase
  endfunction

  function automatic logic fmt_parity(input logic [2:0] fmt);
    return (fmt == FMT_D7P) || (fmt == FMT_D8P);
  endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      line_i,
  input  logic      en_i,
  input  logic      tick_i,
  input  logic [2:0] fmt_i,
  input  logic      parity_odd_i,
  input  logic      stop_two_i,
  output logic      done_o,
  output rx_entry_t entry_o,
  output logic      idle_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic s_meta, s_sync, s_prev;
  logic fall;
  rx_state_e state;
  logic [CW-1:0] cnt;
  logic [3:0] bit_idx, nbits;
  logic [8:0] shreg;
  logic par_en, odd, two, stop_idx, ferr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_meta <= 1'b1;
      s_sync <= 1'b1;
      s_prev <= 1'b1;
    end else begin
      s_meta <= line_i;
      s_sync <= s_meta;
      s_prev <= s_sync;
    end
  end

  assign fall   = s_prev & ~s_sync;
  assign idle_o = (state == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      bit_idx  <= '0;
      nbits    <= 4'd8;
      shreg    <= '0;
      par_en   <= 1'b0;
      odd      <= 1'b0;
      two      <= 1'b0;
      stop_idx <= 1'b0;
      ferr     <= 1'b0;
      done_o   <= 1'b0;
      entry_o  <= '0;
    end else begin
      done_o <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (en_i && fall) begin
            state <= ST_START;
            cnt   <= '0;
          end
        end
        ST_START: begin
          if (!en_i) begin
            state <= ST_IDLE;
          end else if (tick_i) begin
            if (cnt == MID) begin
              cnt <= '0;
              if (s_sync) begin
                state <= ST_IDLE;  // glitch
              end else begin
                state   <= ST_DATA;
                bit_idx <= '0;
                shreg   <= '0;
                nbits   <= fmt_bits(fmt_i);
                par_en  <= fmt_parity(fmt_i);
                odd     <= parity_odd_i;
                two     <= stop_two_i;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (!en_i) begin
            state <= ST_IDLE;
          end else if (tick_i) begin
            if (cnt == LAST) begin
              cnt     <= '0;
              shreg   <= shreg | (9'(s_sync) << bit_idx);
              bit_idx <= bit_idx + 1'b1;
              if (bit_idx == nbits - 4'd1) begin
                state    <= ST_STOP;
                stop_idx <= 1'b0;
                ferr     <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_STOP: begin
          if (!en_i) begin
            state <= ST_IDLE;
          end else if (tick_i) begin
            if (cnt == LAST) begin
              cnt <= '0;
              if (stop_idx || !two) begin
                done_o          <= 1'b1;
                entry_o.pay     <= shreg;
                entry_o.frm_err <= ferr | ~s_sync;
                entry_o.par_err <= par_en & ((^shreg) ^ odd);
                state           <= ST_IDLE;
              end else begin
                stop_idx <= 1'b1;
                ferr     <= ~s_sync;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int HALF  = 8
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      push_i,
  input  rx_entry_t entry_i,
  input  logic      pop_i,
  output rx_entry_t head_o,
  output logic      empty_o,
  output logic      full_o,
  output logic      half_o,
  output logic      ovr_o,
  output logic      pe_any_o,
  output logic      fe_any_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);

  rx_entry_t mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
  logic [CW-1:0] count, pe_cnt, fe_cnt;
  logic pop_ok, push_ok;

  generate
    if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  assign head_o  = mem[rd_ptr];
  assign empty_o = (count == '0);
  assign full_o  = (count == FULL_C);
  assign half_o  = (count > HALF_C);
  assign pe_any_o = (pe_cnt != '0);
  assign fe_any_o = (fe_cnt != '0);
  assign pop_ok  = pop_i && !empty_o;
  // a read in the same cycle frees the slot being written
  assign push_ok = push_i && (!full_o || pop_ok);

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem[wr_ptr] <= entry_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      pe_cnt <= '0;
      fe_cnt <= '0;
      ovr_o  <= 1'b0;
    end else if (clr_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      pe_cnt <= '0;
      fe_cnt <= '0;
      ovr_o  <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= wr_nxt;
      if (pop_ok)  rd_ptr <= rd_nxt;
      count  <= count + CW'(push_ok) - CW'(pop_ok);
      pe_cnt <= pe_cnt + CW'(push_ok & entry_i.par_err) - CW'(pop_ok & head_o.par_err);
      fe_cnt <= fe_cnt + CW'(push_ok & entry_i.frm_err) - CW'(pop_ok & head_o.frm_err);
      if (push_i && !push_ok) ovr_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout #(
  parameter int OSR = 16,
  parameter int TW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          idle_i,
  input  logic          reload_i,
  input  logic [TW-1:0] reload_val_i,
  input  logic          fifo_empty_i,
  output logic          tout_idle_o,
  output logic          tout_busy_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [CW-1:0] pre;
  logic [TW-1:0] cnt;
  logic bit_end;

  assign bit_end = idle_i && tick_i && (pre == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre         <= '0;
      cnt         <= '0;
      tout_idle_o <= 1'b0;
      tout_busy_o <= 1'b0;
    end else if (reload_i) begin
      pre         <= '0;
      cnt         <= reload_val_i;
      tout_idle_o <= 1'b0;
      tout_busy_o <= 1'b0;
    end else begin
      if (!idle_i)     pre <= '0;
      else if (tick_i) pre <= bit_end ? '0 : pre + 1'b1;
      if (bit_end && cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == TW'(1)) begin
          tout_idle_o <= fifo_empty_i;
          tout_busy_o <= ~fifo_empty_i;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_tout.sv
module uart_rx_tout
  import uart_rx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16,
  parameter int HALF  = 8,
  parameter int TW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rx_i,
  input  logic          tx_loop_i,
  input  logic          loopback_i,
  input  logic          rx_en_i,
  input  logic [2:0]    fmt_i,
  input  logic          parity_odd_i,
  input  logic          stop_two_i,
  input  logic          tick_i,
  input  logic [TW-1:0] tout_reload_i,
  input  logic          fifo_clr_i,
  input  logic          rd_en_i,
  output logic [9:0]    rd_data_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          half_full_o,
  output logic          overrun_o,
  output logic          parity_err_o,
  output logic          frame_err_o,
  output logic          tout_idle_o,
  output logic          tout_busy_o
);
  logic      line, smp_done, smp_idle, reload;
  rx_entry_t smp_entry, head;

  assign line = loopback_i ? tx_loop_i : rx_i;

  uart_rx_sampler #(.OSR(OSR)) u_smp (
    .clk_i, .rst_ni,
    .line_i       (line),
    .en_i         (rx_en_i),
    .tick_i,
    .fmt_i,
    .parity_odd_i,
    .stop_two_i,
    .done_o       (smp_done),
    .entry_o      (smp_entry),
    .idle_o       (smp_idle)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .HALF(HALF)) u_fifo (
    .clk_i, .rst_ni,
    .clr_i    (fifo_clr_i),
    .push_i   (smp_done),
    .entry_i  (smp_entry),
    .pop_i    (rd_en_i),
    .head_o   (head),
    .empty_o,
    .full_o,
    .half_o   (half_full_o),
    .ovr_o    (overrun_o),
    .pe_any_o (parity_err_o),
    .fe_any_o (frame_err_o)
  );

  assign reload = smp_done | (rd_en_i & ~empty_o) | fifo_clr_i;

  uart_rx_timeout #(.OSR(OSR), .TW(TW)) u_tout (
    .clk_i, .rst_ni,
    .tick_i,
    .idle_i       (smp_idle),
    .reload_i     (reload),
    .reload_val_i (tout_reload_i),
    .fifo_empty_i (empty_o),
    .tout_idle_o,
    .tout_busy_o
  );

  assign rd_data_o = {head.par_err | head.frm_err, head.pay};
endmodule

// File: rtl/uart_rx_tout_chk.sv
module uart_rx_tout_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_en_i,
  input logic       fifo_clr_i,
  input logic [9:0] rd_data_o,
  input logic       empty_o,
  input logic       full_o,
  input logic       half_full_o,
  input logic       overrun_o,
  input logic       parity_err_o,
  input logic       frame_err_o,
  input logic       tout_idle_o,
  input logic       tout_busy_o
);
  assert_tag_has_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && rd_data_o[9]) |-> (parity_err_o || frame_err_o));

  assert_perr_needs_data_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |-> !empty_o);

  assert_ferr_needs_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !empty_o);

  assert_half_needs_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_full_o |-> !empty_o);

  assert_full_implies_half_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> half_full_o);

  assert_overrun_from_full_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(full_o));

  assert_overrun_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !fifo_clr_i) |=> overrun_o);

  assert_clear_empties_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_i |=> (empty_o && !overrun_o && !parity_err_o && !frame_err_o));

  assert_tout_exclusive_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tout_idle_o && tout_busy_o));

  assert_tout_idle_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_idle_o |-> empty_o);

  assert_tout_busy_data_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tout_busy_o |-> !empty_o);

  assert_read_reloads_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !empty_o) |=> (!tout_idle_o && !tout_busy_o));
endmodule

bind uart_rx_tout uart_rx_tout_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .rd_en_i      (rd_en_i),
  .fifo_clr_i   (fifo_clr_i),
  .rd_data_o    (rd_data_o),
  .empty_o      (empty_o),
  .full_o       (full_o),
  .half_full_o  (half_full_o),
  .overrun_o    (overrun_o),
  .parity_err_o (parity_err_o),
  .frame_err_o  (frame_err_o),
  .tout_idle_o  (tout_idle_o),
  .tout_busy_o  (tout_busy_o)
);

// File: tb/sim_uart_rx_tout.sv
module sim_uart_rx_tout;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0] tcnt;
  logic tick;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0; else tcnt <= tcnt + 2'd1;
  assign tick = (tcnt == 2'd3);

  logic rx_pin = 1'b1, tx_loop = 1'b1, loop_sel = 1'b0, rx_en = 1'b1;
  logic [2:0] fmt = 3'd1;
  logic par_odd = 1'b0, stop_two = 1'b0, clr = 1'b0;
  logic [7:0] reload = 8'd0;
  logic drv_rd = 1'b0, mon_rd = 1'b0, mon_on = 1'b0;
  logic [9:0] rd_data;
  logic empty, full, half, ovr, perr, ferr, t_idle, t_busy;

  uart_rx_tout u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx_pin), .tx_loop_i(tx_loop),
    .loopback_i(loop_sel), .rx_en_i(rx_en), .fmt_i(fmt), .parity_odd_i(par_odd),
    .stop_two_i(stop_two), .tick_i(tick), .tout_reload_i(reload), .fifo_clr_i(clr),
    .rd_en_i(drv_rd | mon_rd), .rd_data_o(rd_data), .empty_o(empty), .full_o(full),
    .half_full_o(half), .overrun_o(ovr), .parity_err_o(perr), .frame_err_o(ferr),
    .tout_idle_o(t_idle), .tout_busy_o(t_busy)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  logic [9:0] exp_q[$];
  string req_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (mon_rd) mon_rd = 1'b0;
      else if (mon_on && !empty) begin
        if (exp_q.size() == 0) chk(0, "R1", "unexpected word", int'(rd_data), 0);
        else begin
          logic [9:0] e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          chk(rd_data == e, r, "scoreboard word", int'(rd_data), int'(e));
        end
        mon_rd = 1'b1;
      end
    end
  end

  function automatic int nb_of(input logic [2:0] f);
    case (f)
      3'd0: return 7;
      3'd2: return 8;
      3'd3, 3'd4: return 9;
      default: return 8;
    endcase
  endfunction

  task automatic align();
    do @(negedge clk); while (tcnt != 2'd0);
  endtask

  task automatic put(input logic b, input bit lp);
    if (lp) tx_loop = b; else rx_pin = b;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] pay, input logic s1, input logic s2,
                      input bit lp, input bit sb, input string req);
    int nb;
    logic [8:0] m;
    logic pe, fe;
    nb = nb_of(fmt);
    m  = pay & 9'((10'h1 << nb) - 10'h1);
    pe = (fmt == 3'd2 || fmt == 3'd3) && ((^m) != par_odd);
    fe = !s1 || (stop_two && !s2);
    if (sb) begin
      exp_q.push_back({pe | fe, m});
      req_q.push_back(req);
    end
    align();
    put(1'b0, lp);
    for (int i = 0; i < nb; i++) put(m[i], lp);
    put(s1, lp);
    if (stop_two) put(s2, lp);
    put(1'b1, lp);
  endtask

  task automatic drain();
    mon_on = 1'b1;
    wait (exp_q.size() == 0);
    repeat (4) @(negedge clk);
    mon_on = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic pop_one();
    @(negedge clk); drv_rd = 1'b1;
    @(negedge clk); drv_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  int k;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(empty && !full && !half && !ovr && !perr && !ferr && !t_idle && !t_busy,
        "R11", "reset flags", {empty, full, half, ovr, perr, ferr, t_idle, t_busy}, 8'h80);

    // R1 formats through the scoreboard
    send(9'h0A5, 1, 1, 0, 1, "R1"); send(9'h03C, 1, 1, 0, 1, "R1");
    drain();
    fmt = 3'd0; send(9'h1D5, 1, 1, 0, 1, "R1"); drain();
    fmt = 3'd4; send(9'h1A5, 1, 1, 0, 1, "R1"); drain();
    fmt = 3'd2; send(9'h035, 1, 1, 0, 1, "R3"); drain();
    fmt = 3'd3; par_odd = 1'b1; send(9'h1F0, 1, 1, 0, 1, "R3"); drain();

    // R3 bad parity held in queue
    fmt = 3'd2; par_odd = 1'b0;
    send(9'h0B5, 1, 1, 0, 1, "R3");
    @(negedge clk);
    chk(perr && !ferr, "R3", "parity flag", {perr, ferr}, 2'b10);
    chk(rd_data[9], "R3", "entry tag", int'(rd_data[9]), 1);
    drain();
    chk(!perr, "R3", "parity flag after drain", int'(perr), 0);

    // R4 second stop bit low
    fmt = 3'd1; stop_two = 1'b1;
    send(9'h05A, 1, 0, 0, 1, "R4");
    @(negedge clk);
    chk(ferr && !perr, "R4", "framing flag", {ferr, perr}, 2'b10);
    drain();
    chk(!ferr, "R4", "framing flag after drain", int'(ferr), 0);
    stop_two = 1'b0;
    send(9'h011, 0, 1, 0, 1, "R4"); drain();

    // R2 glitch and disabled receiver
    align(); rx_pin = 1'b0; repeat (12) @(negedge clk); rx_pin = 1'b1;
    repeat (768) @(negedge clk);
    chk(empty, "R2", "glitch discarded", int'(empty), 1);
    rx_en = 1'b0; send(9'h066, 1, 1, 0, 0, ""); rx_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(empty, "R2", "disabled receive", int'(empty), 1);

    // R10 loopback
    loop_sel = 1'b1;
    send(9'h0C7, 1, 1, 1, 1, "R10"); drain();
    send(9'h099, 1, 1, 0, 0, "");
    repeat (4) @(negedge clk);
    chk(empty, "R10", "pin ignored in loopback", int'(empty), 1);
    loop_sel = 1'b0;

    // calibration of completion cycle
    fork
      send(9'h077, 1, 1, 0, 0, "");
      begin
        align(); k = 0;
        do begin @(negedge clk); k++; end while (empty);
      end
    join
    pop_one();

    // R5 fill
    for (int i = 0; i < 16; i++) begin
      send(9'(i), 1, 1, 0, 0, "");
      if (i == 7) chk(!half, "R5", "8 words not half", int'(half), 0);
      if (i == 8) chk(half, "R5", "9 words half", int'(half), 1);
    end
    chk(full, "R5", "16 words full", int'(full), 1);

    // R7 completion coinciding with a read of a full queue
    fork
      send(9'h0C3, 1, 1, 0, 0, "");
      begin
        align();
        repeat (k - 1) @(negedge clk);
        drv_rd = 1'b1;
        @(negedge clk);
        drv_rd = 1'b0;
      end
    join
    chk(full && !ovr, "R7", "full kept no overrun", {full, ovr}, 2'b10);
    for (int i = 1; i < 16; i++) begin exp_q.push_back(10'(i)); req_q.push_back("R7"); end
    exp_q.push_back(10'h0C3); req_q.push_back("R7");
    drain();

    // R6 overrun drops new frame
    for (int i = 0; i < 16; i++) send(9'(16 + i), 1, 1, 0, 0, "");
    send(9'h0EE, 1, 1, 0, 0, "");
    chk(ovr && full, "R6", "overrun on full", {ovr, full}, 2'b11);
    for (int i = 0; i < 16; i++) begin exp_q.push_back(10'(16 + i)); req_q.push_back("R6"); end
    drain();
    chk(ovr, "R6", "overrun sticky", int'(ovr), 1);
    pulse_clr();
    chk(!ovr && empty, "R8", "clear drops overrun", {ovr, empty}, 2'b01);

    // R8 clear with error entries
    fmt = 3'd2;
    send(9'h0B5, 1, 1, 0, 0, ""); send(9'h012, 0, 1, 0, 0, "");
    chk(perr && ferr, "R8", "flags before clear", {perr, ferr}, 2'b11);
    pulse_clr();
    chk(empty && !perr && !ferr, "R8", "after clear", {empty, perr, ferr}, 3'b100);
    fmt = 3'd1;

    // R11 read of empty queue ignored
    pop_one();
    send(9'h0AB, 1, 1, 0, 0, "");
    chk(!empty && rd_data == 10'h0AB, "R11", "word after empty read", int'(rd_data), 10'h0AB);
    pop_one();
    @(negedge clk);
    chk(empty, "R11", "single pop", int'(empty), 1);

    // R9 timeout
    reload = 8'd3;
    send(9'h03E, 1, 1, 0, 0, "");
    chk(!t_busy && !t_idle, "R9", "no early expiry", {t_busy, t_idle}, 0);
    repeat (192) @(negedge clk);
    chk(t_busy && !t_idle, "R9", "expiry with data", {t_busy, t_idle}, 2'b10);
    pop_one();
    chk(!t_busy && !t_idle && empty, "R9", "read reloads", {t_busy, t_idle, empty}, 3'b001);
    repeat (256) @(negedge clk);
    chk(t_idle && !t_busy, "R9", "expiry when empty", {t_idle, t_busy}, 2'b10);
    reload = 8'd0;
    pulse_clr();
    chk(!t_idle, "R9", "clear reloads", int'(t_idle), 0);
    repeat (640) @(negedge clk);
    chk(!t_idle && !t_busy, "R9", "reload 0 disabled", {t_idle, t_busy}, 0);

    finish_run();
  end
endmodule